// File: doc/BRIEF.md
# Double to Single Store Converter

This block turns a 64-bit double-precision register image into the 32-bit single-precision word that a store-single operation writes to memory. It does not round and does not saturate. Excess fraction bits are dropped. Values whose single exponent would be in range, together with zero, infinity, NaN and magnitudes too large for single format, are produced by a fixed copy of bits. Inputs that fall in the single denormal band are shifted right with their hidden bit included. Anything smaller becomes a zero that keeps its sign.

An operand arrives on `in_data` with a strobe `in_valid`, and the word leaves on `out_word` with `out_valid`. The parameter `PIPE` selects the timing. With `PIPE` = 0 the path is purely combinational. With `PIPE` = 1 a single register stage follows the converter, and a synchronous reset clears it.

Top module: `dbl2sgl_store`

## Requirements
- R1: Input bits 28..0 never affect `out_word`; fraction bits below the single fraction are truncated whatever rounding mode is active.
- R2: `out_word[31]` always equals input bit 63.
- R3: When the 11-bit exponent field (bits 62..52) is 897 or more, or input bits 62..0 are all zero, `out_word[30]` equals input bit 62 and `out_word[29:0]` equals input bits 58..29. This includes magnitudes too large for single format, which are copied and not saturated.
- R4: An exponent field of 2047 (infinity or NaN) takes the copy path of R3, giving a single exponent field of all ones and keeping the quiet bit (input 51) and payload bits 50..29 in `out_word[22:0]`.
- R5: When the exponent field lies in 874..896, `out_word[30:23]` is zero and `out_word[22:0]` is the 24-bit value {1, input bits 51..29} shifted right by 897 minus the exponent field, a shift of 1 to 23.
- R6: When the exponent field is below 874 and input bits 62..0 are not all zero, including double denormals, `out_word[30:0]` is zero.
- R7: With `PIPE` = 0, `out_valid` equals `in_valid` and `out_word` reflects `in_data` in the same cycle.
- R8: With `PIPE` = 1, `out_valid` and `out_word` follow the input one clock later, and a synchronous reset clears `out_valid` and `out_word`.
- R9: With `PIPE` = 1, `out_word` holds its last value over any cycle in which `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, used only when PIPE = 1 |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe |
| in_data | input | 64 | Double-precision register image |
| out_valid | output | 1 | Result strobe |
| out_word | output | 32 | Single-precision store word |

## Verification
The bench builds two instances side by side, one with `PIPE` = 0 and one with `PIPE` = 1. It sweeps every one of the 2048 exponent field values with both signs and six fraction patterns. Together these reach each boundary of the copy, denormal and underflow bands, every denormal shift amount, NaN payloads, and inputs that differ only in truncated bits. The strobe is dropped at regular points in the sweep, so the same run exercises the one-cycle latency, the hold behaviour and the same-cycle combinational path.

// File: rtl/dbl2sgl_store.sv
module dbl2sgl_store #(
  parameter bit PIPE = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [63:0] in_data,
  output logic        out_valid,
  output logic [31:0] out_word
);
  localparam int          EW       = 11;
  localparam int          FW       = 23;
  localparam logic [EW-1:0] COPY_MIN = EW'(897);
  localparam logic [EW-1:0] DEN_MIN  = EW'(874);

  logic          sgn;
  logic [EW-1:0] ex;
  logic          mag_zero;
  logic [EW-1:0] sh_full;
  logic [4:0]    sh;
  logic [FW:0]   mant;
  logic [FW-1:0] den_frac;
  logic [31:0]   conv;

  assign sgn      = in_data[63];
  assign ex       = in_data[62:52];
  assign mag_zero = (in_data[62:0] == 63'd0);
  assign sh_full  = COPY_MIN - ex;
  assign sh       = sh_full[4:0];
  assign mant     = {1'b1, in_data[51:29]};
  assign den_frac = FW'(mant >> sh);

  always_comb begin
    if (ex >= COPY_MIN || mag_zero)
      conv = {sgn, in_data[62], in_data[58:29]};
    else if (ex >= DEN_MIN)
      conv = {sgn, 8'd0, den_frac};
    else
      conv = {sgn, 31'd0};
  end

  logic [63:0] chk_src;

  generate
    if (PIPE) begin : g_pipe
      logic        v_q;
      logic [31:0] w_q;
      logic [63:0] src_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          v_q <= 1'b0;
          w_q <= '0;
        end else begin
          v_q <= in_valid;
          if (in_valid) w_q <= conv;
        end
      end
      always_ff @(posedge clk) src_q <= in_data;
      assign out_valid = v_q;
      assign out_word  = w_q;
      assign chk_src   = src_q;

      a_r8_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
      a_r8_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
      a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_word));
    end else begin : g_comb
      assign out_valid = in_valid;
      assign out_word  = conv;
      assign chk_src   = in_data;
    end
  endgenerate

  a_r2_sign: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_word[31] == chk_src[63]);
  a_r3_copy: assert property (@(posedge clk) disable iff (rst)
    (out_valid && chk_src[62:52] >= COPY_MIN) |->
      (out_word[30] == chk_src[62] && out_word[29:0] == chk_src[58:29]));
  a_r4_special: assert property (@(posedge clk) disable iff (rst)
    (out_valid && chk_src[62:52] == 11'h7FF) |->
      (out_word[30:23] == 8'hFF && out_word[22:0] == chk_src[51:29]));
  a_r5_den_exp: assert property (@(posedge clk) disable iff (rst)
    (out_valid && chk_src[62:52] >= DEN_MIN && chk_src[62:52] < COPY_MIN) |->
      (out_word[30:23] == 8'd0 && out_word[22:0] != 23'd0 || chk_src[62:52] < EW'(875)));
  a_r6_tiny: assert property (@(posedge clk) disable iff (rst)
    (out_valid && chk_src[62:52] < DEN_MIN && chk_src[62:0] != 63'd0) |->
      out_word[30:0] == 31'd0);
endmodule

// File: tb/dbl2sgl_store_tb.sv
module dbl2sgl_store_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] in_data = '0;
  logic        pv, cv;
  logic [31:0] pw, cw;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  dbl2sgl_store #(.PIPE(1'b1)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(pv), .out_word(pw));
  dbl2sgl_store #(.PIPE(1'b0)) u_dut_comb (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(cv), .out_word(cw));

  function automatic logic [31:0] model(input logic [63:0] d);
    int ex, e, s, m;
    ex = int'(d[62:52]);
    e  = ex - 1023;
    if (e > -127 || d[62:0] == 63'd0)
      return {d[63], d[62], d[58:29]};
    else if (e >= -149) begin
      s = -126 - e;
      m = (1 << 23) + int'(d[51:29]);
      return {d[63], 8'd0, 23'(m / (1 << s))};
    end
    return {d[63], 31'd0};
  endfunction

  function automatic string tag_of(input logic [63:0] d, input int p);
    int ex;
    ex = int'(d[62:52]);
    if (ex == 2047) return "R4";
    if (ex >= 897 || d[62:0] == 63'd0) return (p == 5) ? "R1" : "R3";
    if (ex >= 874) return "R5";
    return "R6";
  endfunction

  function automatic logic [51:0] frac_pat(input int p);
    case (p)
      0: return 52'd0;
      1: return {52{1'b1}};
      2: return 52'h8_0000_0000_0000;
      3: return 52'h5_5555_5555_5555;
      4: return 52'h0_0000_2000_0000;
      default: return 52'h0_0000_1FFF_FFFF;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic        prev_v;
    logic [31:0] prev_exp;
    logic [31:0] held;
    string       prev_tag;
    logic [63:0] d;
    logic [31:0] ex_w;
    int idx;
    repeat (3) @(negedge clk);
    chk("R8 reset valid", {31'd0, pv}, 32'd0);
    chk("R8 reset word", pw, 32'd0);
    in_valid = 1'b1;
    in_data  = 64'h4000_0000_0000_0000;
    @(negedge clk);
    chk("R8 valid held in reset", {31'd0, pv}, 32'd0);
    in_valid = 1'b0;
    rst = 1'b0;
    prev_v = 1'b0; prev_exp = '0; held = '0; prev_tag = "R8"; idx = 0;
    for (int ex = 0; ex < 2048; ex++) begin
      for (int p = 0; p < 6; p++) begin
        for (int s = 0; s < 2; s++) begin
          @(negedge clk);
          chk("R8 valid latency", {31'd0, pv}, {31'd0, prev_v});
          if (prev_v) begin
            chk({prev_tag, " R8 piped"}, pw, prev_exp);
            held = prev_exp;
          end else
            chk("R9 hold", pw, held);
          d = {s[0], ex[10:0], frac_pat(p)};
          in_data  = d;
          in_valid = (idx % 7) != 3;
          ex_w = model(d);
          #1;
          chk("R7 comb valid", {31'd0, cv}, {31'd0, in_valid});
          chk({tag_of(d, p), " comb"}, cw, ex_w);
          checks++;
          if (cw[31] !== d[63]) begin
            fails++;
            $display("FAIL R2 actual=%b expected=%b", cw[31], d[63]);
          end
          prev_v = in_valid; prev_exp = ex_w; prev_tag = tag_of(d, p);
          idx++;
        end
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    if (prev_v) chk({prev_tag, " R8 piped"}, pw, prev_exp);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule